// File: doc/BRIEF.md
# Memory String Operation Engine

This block runs string and block operations against a byte-addressed memory port, one access at a time. A command loads three working registers: a destination pointer, a source register and a count. The source register holds a second pointer for copy and compare operations, and a fill or search value for the others. The engine then loops over the memory until the termination rule of the selected operation is met. It pulses a done strobe when it finishes and leaves its working registers visible on the outputs.

Seven operations are supported: copy forward, copy backward, copy that stops after a zero byte, fill, scan until a match, scan while matching, and byte string compare. Fill and the two scans work on byte, halfword or word elements. The copies and the compare always move single bytes. The compare and the scans update a zero flag and a carry flag from the last pair of values they compared.

The memory port carries the element in the low bits of its data buses, so lane steering is left to the memory side. Alignment is not checked, and an operation cannot be stopped once it has started.

Top module: `str_engine`

## Requirements
- R1: A command is taken only when `busy_o` is low and `cmd_valid_i` is high. Taking it loads the destination, source and count registers. `cmd_valid_i` has no effect while `busy_o` is high. Op code 7 is reserved: it makes no memory access and leaves the flags unchanged.
- R2: Op 0, forward copy, repeats the following until the count is zero. It reads the byte at the source pointer, writes it at the destination pointer, adds 1 to both pointers and subtracts 1 from the count.
- R3: Op 1, backward copy, does the same as op 0 but subtracts 1 from both pointers after each byte.
- R4: Op 2 copies forward like op 0. It also stops right after it has written a zero byte.
- R5: Op 3, fill, writes the low element of the source register at the destination pointer, count times. Size code 0 selects 1 byte, code 1 selects 2 bytes, and codes 2 and 3 select 4 bytes. The pointer advances by the element size after each write.
- R6: Op 4 reads elements at the destination pointer. After each read it subtracts 1 from the count and advances the pointer. It stops after the first element equal to the size-masked source value, or when the count reaches zero.
- R7: Op 5 follows the same sequence as op 4 but stops after the first element that differs from the value. For ops 4 and 5, a count of zero at the start leaves the flags unchanged.
- R8: Op 6 reads one byte through the destination pointer and then one through the source pointer. It then adds 1 to both pointers and subtracts 1 from the count. It stops on a mismatch, on an equal pair of zero bytes, or when the count reaches zero. A count of zero at the start sets Z and C.
- R9: After ops 4, 5 and 6, Z is 1 when the last reference value equals the last memory value. C is 1 when the reference is unsigned greater than or equal to the memory value. The reference is the masked source value for ops 4 and 5, and the destination-side byte for op 6.
- R10: At most one access is outstanding at a time. A request holds its address, direction and data until `mem_ack_i` is seen. Each copy step issues its read before its write.
- R11: `done_o` is a one-cycle pulse. For a zero count or op 7 it is high in the cycle after the command is taken, with no access made.
- R12: After reset the engine is idle, and the registers and flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Operation code |
| cmd_size_i | input | 2 | Element size code for fill and scans |
| cmd_dst_i | input | AW | Initial destination pointer |
| cmd_src_i | input | DW | Initial source pointer or value |
| cmd_cnt_i | input | CW | Initial element count |
| busy_o | output | 1 | Engine is running an operation |
| done_o | output | 1 | Completion pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address |
| mem_size_o | output | 2 | Access size code |
| mem_wdata_o | output | DW | Write data, element in the low bits |
| mem_ack_i | input | 1 | Access completes at this edge |
| mem_rdata_i | input | DW | Read data, element in the low bits, valid with ack |
| dst_o | output | AW | Destination pointer register |
| src_o | output | DW | Source register |
| cnt_o | output | CW | Count register |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
Every memory access finishes at the clock edge where `mem_ack_i` is high while `mem_req_o` is high. The bench model checks each access at the half-cycle before that edge, against the next entry of its expected access queue. The registers and flags are updated at the edge that completes the last access. `done_o` rises in the cycle after that edge, so the final values are sampled at the falling edge where `done_o` is first seen high. A command with a zero count, or with op 7, must show `done_o` at the first falling edge after the command is taken. The bench checks that edge exactly and, one cycle later, checks that the pulse has ended.

// File: rtl/str_pkg.sv
package str_pkg;

  typedef enum logic [2:0] {
    OP_COPY_FWD   = 3'd0,
    OP_COPY_BWD   = 3'd1,
    OP_COPY_UZ    = 3'd2,
    OP_FILL       = 3'd3,
    OP_SCAN_UNTIL = 3'd4,
    OP_SCAN_WHILE = 3'd5,
    OP_CMP        = 3'd6,
    OP_NONE       = 3'd7
  } str_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_WR,
    ST_DONE
  } str_state_e;

  function automatic logic [2:0] size_bytes(logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/str_regs.sv
module str_regs
  import str_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] ld_dst_i,
  input  logic [DW-1:0] ld_src_i,
  input  logic [CW-1:0] ld_cnt_i,
  input  logic          step_i,
  input  logic          step_src_i,
  input  logic          back_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] dst_o,
  output logic [DW-1:0] src_o,
  output logic [CW-1:0] cnt_o,
  output logic          cnt_last_o
);

  logic [AW-1:0] dst_q;
  logic [DW-1:0] src_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] dst_inc;

  assign dst_inc = AW'(size_bytes(size_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q <= '0;
      src_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      dst_q <= ld_dst_i;
      src_q <= ld_src_i;
      cnt_q <= ld_cnt_i;
    end else if (step_i) begin
      dst_q <= back_i ? dst_q - dst_inc : dst_q + dst_inc;
      if (step_src_i) src_q <= back_i ? src_q - DW'(1) : src_q + DW'(1);
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign dst_o      = dst_q;
  assign src_o      = src_q;
  assign cnt_o      = cnt_q;
  assign cnt_last_o = (cnt_q == CW'(1));

  // R6: a step never runs the count below zero
  a_r6_cnt_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> cnt_q != '0);

endmodule

// File: rtl/str_flags.sv
module str_flags #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [DW-1:0] ref_i,
  input  logic [DW-1:0] mem_i,
  output logic          z_o,
  output logic          c_o
);

  logic z_q, c_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else if (upd_i) begin
      z_q <= (ref_i == mem_i);
      c_q <= (ref_i >= mem_i);
    end
  end

  assign z_o = z_q;
  assign c_o = c_q;

  // R9: equality always implies no borrow
  a_r9_z_implies_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_q |-> c_q);

  // R9: flags hold between updates
  a_r9_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(z_q) && $stable(c_q));

endmodule

// File: rtl/str_fsm.sv
module str_fsm
  import str_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [1:0]    cmd_size_i,
  input  logic          cmd_cnt_zero_i,
  input  logic [AW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  input  logic          cnt_last_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          load_o,
  output logic          step_o,
  output logic          step_src_o,
  output logic          back_o,
  output logic [1:0]    size_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          flag_upd_o,
  output logic [DW-1:0] flag_ref_o,
  output logic [DW-1:0] flag_mem_o
);

  str_state_e    state_q, state_d;
  str_op_e       op_q, cmd_op;
  logic [1:0]    size_q;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] mask;
  logic [DW-1:0] rd_val;
  logic [DW-1:0] scan_ref;
  logic [1:0]    eff_size;
  logic          is_copy, is_scan, ack, scan_hit, stop;

  assign cmd_op   = str_op_e'(cmd_op_i);
  assign is_copy  = (op_q == OP_COPY_FWD) || (op_q == OP_COPY_BWD) || (op_q == OP_COPY_UZ);
  assign is_scan  = (op_q == OP_SCAN_UNTIL) || (op_q == OP_SCAN_WHILE);
  assign eff_size = (is_scan || op_q == OP_FILL) ? size_q : 2'd0;

  always_comb begin
    case (eff_size)
      2'd0:    mask = DW'(8'hFF);
      2'd1:    mask = DW'(16'hFFFF);
      default: mask = '1;
    endcase
  end

  assign ack      = mem_req_o && mem_ack_i;
  assign rd_val   = mem_rdata_i & mask;
  assign scan_ref = src_i & mask;
  assign scan_hit = (rd_val == scan_ref);

  always_comb begin
    state_d    = state_q;
    step_o     = 1'b0;
    stop       = 1'b0;
    flag_upd_o = 1'b0;
    flag_ref_o = '0;
    flag_mem_o = '0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid_i) begin
          if (cmd_op == OP_NONE || cmd_cnt_zero_i) begin
            state_d    = ST_DONE;
            flag_upd_o = (cmd_op == OP_CMP);
          end else if (cmd_op == OP_FILL) begin
            state_d = ST_WR;
          end else begin
            state_d = ST_RD_A;
          end
        end
      end
      ST_RD_A: begin
        if (ack) begin
          if (is_copy) begin
            state_d = ST_WR;
          end else if (op_q == OP_CMP) begin
            state_d = ST_RD_B;
          end else begin
            step_o     = 1'b1;
            flag_upd_o = 1'b1;
            flag_ref_o = scan_ref;
            flag_mem_o = rd_val;
            stop       = cnt_last_i || ((op_q == OP_SCAN_UNTIL) ? scan_hit : !scan_hit);
            state_d    = stop ? ST_DONE : ST_RD_A;
          end
        end
      end
      ST_RD_B: begin
        if (ack) begin
          step_o     = 1'b1;
          flag_upd_o = 1'b1;
          flag_ref_o = hold_q;
          flag_mem_o = rd_val;
          stop       = cnt_last_i || (hold_q != rd_val) || (hold_q == '0);
          state_d    = stop ? ST_DONE : ST_RD_A;
        end
      end
      ST_WR: begin
        if (ack) begin
          step_o  = 1'b1;
          stop    = cnt_last_i || (op_q == OP_COPY_UZ && hold_q[7:0] == 8'h00);
          state_d = stop ? ST_DONE : ((op_q == OP_FILL) ? ST_WR : ST_RD_A);
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      size_q  <= 2'd0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        op_q   <= cmd_op;
        size_q <= cmd_size_i;
      end
      if (state_q == ST_RD_A && ack) hold_q <= rd_val;
    end
  end

  assign load_o     = (state_q == ST_IDLE) && cmd_valid_i;
  assign step_src_o = is_copy || (op_q == OP_CMP);
  assign back_o     = (op_q == OP_COPY_BWD);
  assign size_o     = eff_size;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);

  assign mem_req_o  = (state_q == ST_RD_A) || (state_q == ST_RD_B) || (state_q == ST_WR);
  assign mem_we_o   = (state_q == ST_WR);
  assign mem_size_o = eff_size;
  assign mem_wdata_o = (op_q == OP_FILL) ? (src_i & mask) : hold_q;

  always_comb begin
    case (state_q)
      ST_RD_A: mem_addr_o = is_copy ? src_i[AW-1:0] : dst_i;
      ST_RD_B: mem_addr_o = src_i[AW-1:0];
      default: mem_addr_o = dst_i;
    endcase
  end

  // R10: a pending request is held unchanged until acknowledged
  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                  && $stable(mem_wdata_o));

  // R11: completion strobe lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R1: nothing reaches memory while idle
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  // R10: a copy write follows its read directly
  a_r10_copy_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !mem_we_o && is_copy) |=> mem_req_o && mem_we_o);

endmodule

// File: rtl/str_engine.sv
module str_engine
  import str_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [1:0]    cmd_size_i,
  input  logic [AW-1:0] cmd_dst_i,
  input  logic [DW-1:0] cmd_src_i,
  input  logic [CW-1:0] cmd_cnt_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] dst_o,
  output logic [DW-1:0] src_o,
  output logic [CW-1:0] cnt_o,
  output logic          flag_z_o,
  output logic          flag_c_o
);

  logic          load, step, step_src, back, cnt_last, flag_upd;
  logic [1:0]    step_size;
  logic [DW-1:0] flag_ref, flag_mem;

  str_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_op_i       (cmd_op_i),
    .cmd_size_i     (cmd_size_i),
    .cmd_cnt_zero_i (cmd_cnt_i == '0),
    .dst_i          (dst_o),
    .src_i          (src_o),
    .cnt_last_i     (cnt_last),
    .mem_ack_i      (mem_ack_i),
    .mem_rdata_i    (mem_rdata_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .load_o         (load),
    .step_o         (step),
    .step_src_o     (step_src),
    .back_o         (back),
    .size_o         (step_size),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_size_o     (mem_size_o),
    .mem_wdata_o    (mem_wdata_o),
    .flag_upd_o     (flag_upd),
    .flag_ref_o     (flag_ref),
    .flag_mem_o     (flag_mem)
  );

  str_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .ld_dst_i   (cmd_dst_i),
    .ld_src_i   (cmd_src_i),
    .ld_cnt_i   (cmd_cnt_i),
    .step_i     (step),
    .step_src_i (step_src),
    .back_i     (back),
    .size_i     (step_size),
    .dst_o      (dst_o),
    .src_o      (src_o),
    .cnt_o      (cnt_o),
    .cnt_last_o (cnt_last)
  );

  str_flags #(.DW(DW)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (flag_upd),
    .ref_i  (flag_ref),
    .mem_i  (flag_mem),
    .z_o    (flag_z_o),
    .c_o    (flag_c_o)
  );

endmodule

// File: tb/str_engine_tb_top.sv
module str_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk, rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [1:0]    cmd_size;
  logic [AW-1:0] cmd_dst;
  logic [DW-1:0] cmd_src;
  logic [CW-1:0] cmd_cnt;
  logic          busy_o, done_o, mem_req_o, mem_we_o, flag_z_o, flag_c_o;
  logic [AW-1:0] mem_addr_o, dst_o;
  logic [1:0]    mem_size_o;
  logic [DW-1:0] mem_wdata_o, src_o;
  logic [CW-1:0] cnt_o;
  logic          mem_ack;
  logic [DW-1:0] mem_rdata;

  str_engine #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_size_i(cmd_size),
    .cmd_dst_i(cmd_dst), .cmd_src_i(cmd_src), .cmd_cnt_i(cmd_cnt),
    .busy_o(busy_o), .done_o(done_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_size_o(mem_size_o), .mem_wdata_o(mem_wdata_o),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .dst_o(dst_o), .src_o(src_o), .cnt_o(cnt_o),
    .flag_z_o(flag_z_o), .flag_c_o(flag_c_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0]  mem  [256];
  logic [7:0]  mmem [256];
  logic        exp_we   [$];
  int          exp_addr [$];
  int          exp_size [$];
  logic [31:0] exp_data [$];
  int          e_dst, e_cnt;
  logic [31:0] e_src;
  logic        m_z = 1'b0, m_c = 1'b0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int sbytes(int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] smask(int sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mrd(int a, int sz);
    logic [31:0] v = '0;
    for (int k = 0; k < sbytes(sz); k++) v[8*k +: 8] = mmem[(a + k) & 255];
    return v;
  endfunction

  task automatic push(logic we, int a, int sz, logic [31:0] d);
    exp_we.push_back(we);
    exp_addr.push_back(a);
    exp_size.push_back(sz);
    exp_data.push_back(d);
  endtask

  // behavioural reference of every operation
  task automatic model(int op, int sz, int dst, logic [31:0] src, int cnt);
    logic [31:0] r, e, a, b;
    int p, q;
    e_dst = dst; e_src = src; e_cnt = cnt;
    case (op)
      0, 1, 2: begin
        while (e_cnt != 0) begin
          p = e_src;
          b = {24'h0, mmem[p & 255]};
          push(1'b0, p, 0, 32'h0);
          mmem[e_dst & 255] = b[7:0];
          push(1'b1, e_dst, 0, b);
          if (op == 1) begin e_dst--; e_src--; end
          else begin e_dst++; e_src++; end
          e_cnt--;
          if (op == 2 && b == 0) break;
        end
      end
      3: begin
        r = src & smask(sz);
        while (e_cnt != 0) begin
          push(1'b1, e_dst, sz, r);
          for (int k = 0; k < sbytes(sz); k++) mmem[(e_dst + k) & 255] = r[8*k +: 8];
          e_dst += sbytes(sz);
          e_cnt--;
        end
      end
      4, 5: begin
        r = src & smask(sz);
        if (e_cnt != 0) begin
          e = '0;
          while (e_cnt != 0) begin
            e_cnt--;
            e = mrd(e_dst, sz);
            push(1'b0, e_dst, sz, 32'h0);
            e_dst += sbytes(sz);
            if (op == 4 && e == r) break;
            if (op == 5 && e != r) break;
          end
          m_z = (r == e);
          m_c = (r >= e);
        end
      end
      6: begin
        a = '0; b = '0;
        while (e_cnt != 0) begin
          p = e_dst; q = e_src;
          a = {24'h0, mmem[p & 255]};
          push(1'b0, p, 0, 32'h0);
          b = {24'h0, mmem[q & 255]};
          push(1'b0, q, 0, 32'h0);
          e_dst++; e_src++; e_cnt--;
          if (a != b || a == 0) break;
        end
        m_z = (a == b);
        m_c = (a >= b);
      end
      default: ;
    endcase
  endtask

  // memory responder with pseudo-random latency; each access checked against the model
  logic [31:0] seed = 32'h1357_9BDF;
  int dly = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack   = 1'b0;
      mem_rdata = '0;
    end else if (mem_req_o && dly == 0) begin
      mem_ack = 1'b1;
      if (exp_we.size() == 0) begin
        chk(1'b0, "R10 unexpected access", {14'h0, mem_we_o, mem_size_o, mem_addr_o}, 32'h0);
      end else begin
        logic        w;
        int          a, s;
        logic [31:0] d;
        w = exp_we.pop_front(); a = exp_addr.pop_front();
        s = exp_size.pop_front(); d = exp_data.pop_front();
        chk(w == mem_we_o && a == int'(mem_addr_o) && s == int'(mem_size_o),
            "R10 access kind/address/size",
            {13'h0, mem_we_o, mem_size_o, mem_addr_o}, {13'h0, w, s[1:0], a[15:0]});
        if (w) chk((mem_wdata_o & smask(s)) == d, "R10 write data", mem_wdata_o, d);
      end
      if (mem_we_o) begin
        for (int k = 0; k < sbytes(int'(mem_size_o)); k++)
          mem[(int'(mem_addr_o) + k) & 255] = mem_wdata_o[8*k +: 8];
      end else begin
        logic [31:0] v = '0;
        for (int k = 0; k < sbytes(int'(mem_size_o)); k++)
          v[8*k +: 8] = mem[(int'(mem_addr_o) + k) & 255];
        mem_rdata = v | (~smask(int'(mem_size_o)) & 32'hA5A5_A5A5);
      end
      seed = seed * 32'd1103515245 + 32'd12345;
      dly  = int'(seed[17:16]) % 3;
    end else begin
      mem_ack = 1'b0;
      if (mem_req_o && dly > 0) dly--;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0x%0h expected=0x0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(int op, int sz, int dst, logic [31:0] src, int cnt, string tag, bit stray);
    int n, mis;
    for (int i = 0; i < 256; i++) mmem[i] = mem[i];
    model(op, sz, dst, src, cnt);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[2:0]; cmd_size = sz[1:0];
    cmd_dst = dst[AW-1:0]; cmd_src = src; cmd_cnt = cnt[CW-1:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 1;
    if (cnt == 0 || op == 7)
      chk(done_o == 1'b1, {tag, " R11 done one cycle after command"}, done_o, 1);
    while (!done_o && n < 5000) begin
      if (stray && n == 2) begin
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_size = 2'd2;
        cmd_dst = 16'h0000; cmd_src = 32'hFFFF_FFFF; cmd_cnt = 16'd50;
      end
      if (stray && n == 3) cmd_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    cmd_valid = 1'b0;
    chk(done_o == 1'b1, {tag, " R11 done seen"}, done_o, 1);
    chk(int'(dst_o) == (e_dst & 16'hFFFF), {tag, " final dst"}, dst_o, e_dst);
    chk(src_o == e_src, {tag, " final src"}, src_o, e_src);
    chk(int'(cnt_o) == e_cnt, {tag, " final count"}, cnt_o, e_cnt);
    chk(flag_z_o == m_z && flag_c_o == m_c, {tag, " R9 flags Z,C"},
        {flag_z_o, flag_c_o}, {m_z, m_c});
    chk(exp_we.size() == 0, {tag, " R10 all expected accesses made"}, exp_we.size(), 0);
    exp_we.delete(); exp_addr.delete(); exp_size.delete(); exp_data.delete();
    mis = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== mmem[i]) mis++;
    chk(mis == 0, {tag, " memory image"}, mis, 0);
    @(negedge clk);
    chk(!done_o && !busy_o, {tag, " R11 pulse ended, idle"}, {done_o, busy_o}, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_op = '0; cmd_size = '0; cmd_dst = '0; cmd_src = '0; cmd_cnt = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + 3) & 255);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy_o && !done_o && !mem_req_o, "R12 idle after reset", {busy_o, done_o, mem_req_o}, 0);
    chk(dst_o == 0 && src_o == 0 && cnt_o == 0, "R12 registers zero", src_o, 0);
    chk(!flag_z_o && !flag_c_o, "R12 flags zero", {flag_z_o, flag_c_o}, 0);

    run(0, 0, 'h40, 32'h10, 5, "R2 forward copy R1 stray command ignored", 1'b1);
    run(1, 0, 'h9F, 32'h2F, 6, "R3 backward copy", 1'b0);

    mem['h20] = 8'h41; mem['h21] = 8'h42; mem['h22] = 8'h00; mem['h23] = 8'h43;
    run(2, 0, 'h60, 32'h20, 10, "R4 copy-until-zero stops after zero", 1'b0);
    mem['h30] = 8'h11; mem['h31] = 8'h12; mem['h32] = 8'h13;
    run(2, 0, 'h68, 32'h30, 3, "R4 copy-until-zero count runs out", 1'b0);

    run(3, 0, 'h80, 32'h1234_56AB, 3, "R5 fill byte", 1'b0);
    run(3, 1, 'h88, 32'hCAFE_BEEF, 2, "R5 fill halfword", 1'b0);
    run(3, 2, 'h90, 32'hDEAD_C0DE, 2, "R5 fill word", 1'b0);

    mem['hA0] = 8'h11; mem['hA1] = 8'h11; mem['hA2] = 8'h22; mem['hA3] = 8'h22;
    mem['hA4] = 8'h33; mem['hA5] = 8'h33; mem['hA6] = 8'h44; mem['hA7] = 8'h44;
    run(4, 1, 'hA0, 32'hFFFF_3333, 4, "R6 scan-until halfword hit", 1'b0);
    mem['hB0] = 8'h05; mem['hB1] = 8'h06; mem['hB2] = 8'h07;
    run(4, 0, 'hB0, 32'h04, 3, "R6 scan-until exhausted", 1'b0);

    for (int i = 0; i < 8; i++) mem['hC0 + i] = 8'h77;
    mem['hC8] = 8'h10; mem['hC9] = 8'h00; mem['hCA] = 8'h00; mem['hCB] = 8'h00;
    run(5, 2, 'hC0, 32'h7777_7777, 5, "R7 scan-while word", 1'b0);
    run(4, 0, 'hC0, 32'h77, 0, "R7 zero count keeps flags", 1'b0);

    mem['hD0] = 8'h61; mem['hD1] = 8'h62; mem['hD2] = 8'h00; mem['hD3] = 8'h78;
    mem['hE0] = 8'h61; mem['hE1] = 8'h62; mem['hE2] = 8'h00; mem['hE3] = 8'h79;
    run(6, 0, 'hD0, 32'hE0, 8, "R8 compare equal to zero byte", 1'b0);
    mem['hE1] = 8'h63;
    run(6, 0, 'hD0, 32'hE0, 10, "R8 compare mismatch ref lower", 1'b0);
    run(6, 0, 'hD0, 32'hE0, 0, "R8 compare zero count", 1'b0);
    mem['hD4] = 8'h7A; mem['hE4] = 8'h61;
    run(6, 0, 'hD4, 32'hE4, 4, "R8 compare mismatch ref higher", 1'b0);

    run(0, 0, 'h50, 32'h12, 0, "R11 zero count copy", 1'b0);
    run(7, 0, 'h50, 32'h12, 4, "R1 reserved op", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule